// File: doc/BRIEF.md
# Windowed Register Trap Entry Sequencer

This block carries out trap entry for a processor whose integer registers live in a rotating window file. When the pipeline raises a trap request with an 8-bit trap type, the block does three things. It moves the current window pointer down by one, wrapping modulo the window count. It records the supervisor state, drops trap enable and writes the trap type into the trap base register. It then stores the faulting PC and next PC into two local registers of the new window. The new window's locals are not shared with any neighbour, so the saved return pair cannot clobber live caller state.

The register file has a single write port, so the sequence takes two cycles, one store per cycle. The block shows a busy flag for both cycles. In the second cycle it raises a one-cycle done pulse that also carries the redirected fetch address, equal to the updated trap base register, together with that address plus 4. A separate load path lets the processor's state-write instructions set the window pointer, the state bits and the trap base field while no trap is in progress.

Top module: `trap_entry_seq`

## Requirements
- R1: After a synchronous active-low reset: busy=0, done=0, rf_we=0, cwp=0, sup=1, prev_sup=0, trap_en=0, tbr=0.
- R2: An accepted trap sets cwp to (cwp - 1) modulo NWIN. NWIN is a power of two, and a pointer of 0 becomes NWIN-1. The new value is visible in the cycle after acceptance.
- R3: An accepted trap clears trap_en, copies the old sup into prev_sup and sets sup to 1.
- R4: An accepted trap keeps tbr[XLEN-1:12] and sets tbr[11:4] to trap_type and tbr[3:0] to 0.
- R5: In the first cycle after acceptance, rf_we=1 writes cur_pc (as sampled at acceptance) to window register 17 of the new window. In the second cycle it writes cur_npc to register 18. A window-relative register r (8..31) of window w has physical address (w*16 + r - 8) mod (NWIN*16).
- R6: busy is 1 for exactly the two write cycles. done is a one-cycle pulse in the second of them, with new_pc = tbr and new_npc = tbr + 4.
- R7: trap_req and ld_req are ignored while busy. The state after the sequence reflects exactly one trap.
- R8: ld_req while idle loads cwp, sup, prev_sup, trap_en and tbr = {ld_tba, 12'h000} for the next cycle. If trap_req is asserted in the same cycle, the trap wins and the load is dropped.
- R9: rf_we is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request, accepted when idle |
| trap_type | input | 8 | Trap type for the vector |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_npc | input | XLEN | Next PC of the trapping instruction |
| ld_req | input | 1 | State load from a state-write instruction |
| ld_cwp | input | log2(NWIN) | Window pointer to load |
| ld_sup | input | 1 | Supervisor bit to load |
| ld_prev_sup | input | 1 | Previous-supervisor bit to load |
| ld_trap_en | input | 1 | Trap-enable bit to load |
| ld_tba | input | XLEN-12 | Trap base field to load |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of the sequence, fetch redirect valid |
| new_pc | output | XLEN | Redirect PC |
| new_npc | output | XLEN | Redirect next PC |
| cwp | output | log2(NWIN) | Current window pointer |
| sup | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Previous-supervisor bit |
| trap_en | output | 1 | Trap-enable bit |
| tbr | output | XLEN | Trap base register |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | log2(NWIN)+4 | Physical register address |
| rf_wdata | output | XLEN | Register file write data |

## Verification
The bench loads every window pointer with both supervisor values, traps from each and computes the decremented pointer and physical write addresses arithmetically. The sweep includes the 0 to NWIN-1 wrap. A design that subtracted without wrapping would show a wrong pointer there and store the return pair in the wrong window. Trap types 0x00 and 0xFF check that the type lands in bits 11:4 without touching the base or the low nibble. A shift off by one would corrupt either the vector or the base. Some runs hold trap_req and ld_req high through the whole sequence. A design that re-accepted them would decrement twice or reload the pointer. A same-cycle load and trap checks that the trap takes priority.

// File: rtl/trap_pkg.sv
// Shared types and constants for the trap entry sequencer.
// Assumes a window-relative register numbering of 0..31 where 8..31 are windowed.
package trap_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WR_PC  = 2'd1,
        SQ_WR_NPC = 2'd2
    } seq_state_e;

    localparam int          WIN_STRIDE   = 16;
    localparam logic [4:0]  SLOT_RET_PC  = 5'd17;
    localparam logic [4:0]  SLOT_RET_NPC = 5'd18;
    localparam logic [4:0]  FIRST_WINREG = 5'd8;

endpackage

// File: rtl/trap_win_map.sv
// Maps a window-relative register index onto the physical register file.
// Assumes NWIN is a power of two, so address wrap is plain truncation.
module trap_win_map #(
    parameter int NWIN = 8,
    localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int AW  = CW + 4
) (
    input  logic [CW-1:0] win,
    input  logic [4:0]    reg_idx,
    output logic [AW-1:0] phys
);
    import trap_pkg::*;

    logic [AW-1:0] base_addr;

    // Window base address: pointer times the window stride.
    always_comb base_addr = {win, 4'b0000};

    // Physical address wraps modulo NWIN*WIN_STRIDE by truncation.
    always_comb phys = base_addr + AW'(reg_idx) - AW'(FIRST_WINREG);

endmodule

// File: rtl/trap_state_regs.sv
// Holds the window pointer, supervisor/previous-supervisor/trap-enable bits
// and the trap base register. Applies a trap entry or a state load.
// Assumes accept and ld_en are never both high (the sequencer ensures it).
module trap_state_regs #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int TTW  = 8,
    localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int BW  = XLEN - TTW - 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [TTW-1:0]  tt,
    input  logic            ld_en,
    input  logic [CW-1:0]   ld_cwp,
    input  logic            ld_sup,
    input  logic            ld_prev_sup,
    input  logic            ld_trap_en,
    input  logic [BW-1:0]   ld_tba,
    input  logic            busy,
    output logic [CW-1:0]   cwp,
    output logic            sup,
    output logic            prev_sup,
    output logic            trap_en,
    output logic [XLEN-1:0] tbr
);
    logic [BW-1:0]  tba_q;
    logic [TTW-1:0] tt_q;

    // Window pointer: decrement with wrap on trap, or load.
    always_ff @(posedge clk) begin
        if (!rst_n)      cwp <= '0;
        else if (accept) cwp <= cwp - CW'(1);
        else if (ld_en)  cwp <= ld_cwp;
    end

    // Processor state bits: save supervisor, force supervisor, drop trap enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup      <= 1'b1;
            prev_sup <= 1'b0;
            trap_en  <= 1'b0;
        end else if (accept) begin
            prev_sup <= sup;
            sup      <= 1'b1;
            trap_en  <= 1'b0;
        end else if (ld_en) begin
            sup      <= ld_sup;
            prev_sup <= ld_prev_sup;
            trap_en  <= ld_trap_en;
        end
    end

    // Trap base register fields: base kept on trap, type field overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tba_q <= '0;
            tt_q  <= '0;
        end else if (accept) begin
            tt_q  <= tt;
        end else if (ld_en) begin
            tba_q <= ld_tba;
            tt_q  <= '0;
        end
    end

    // Trap base register view with a zero low nibble.
    always_comb tbr = {tba_q, tt_q, 4'b0000};

    AST_CWP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cwp == CW'($past(cwp) - CW'(1)));                         // R2
    AST_SUP_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (sup && !trap_en && prev_sup == $past(sup)));            // R3
    AST_TBR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tbr[TTW+3:4] == $past(tt) &&
                    tbr[XLEN-1:TTW+4] == $past(tbr[XLEN-1:TTW+4])));         // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cwp) && $stable(tbr) && $stable(sup)));           // R7

endmodule

// File: rtl/trap_seq_fsm.sv
// Two-step trap entry sequencer: accepts a trap when idle, captures the
// return PC pair and steps through one register write per cycle.
// Assumes the register file accepts a write every cycle.
module trap_seq_fsm #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic            ld_req,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_npc,
    output logic            accept,
    output logic            ld_en,
    output trap_pkg::seq_state_e state,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] ret_pc,
    output logic [XLEN-1:0] ret_npc
);
    import trap_pkg::*;

    // Acceptance and load arbitration: only when idle, trap before load.
    always_comb begin
        accept = trap_req && (state == SQ_IDLE);
        ld_en  = ld_req && !trap_req && (state == SQ_IDLE);
    end

    // State progression: idle -> write PC -> write next PC -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else begin
            unique case (state)
                SQ_IDLE:   if (accept) state <= SQ_WR_PC;
                SQ_WR_PC:  state <= SQ_WR_NPC;
                SQ_WR_NPC: state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    // Return PC pair capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_pc  <= '0;
            ret_npc <= '0;
        end else if (accept) begin
            ret_pc  <= cur_pc;
            ret_npc <= cur_npc;
        end
    end

    // Status decode of the state register.
    always_comb begin
        busy = (state != SQ_IDLE);
        done = (state == SQ_WR_NPC);
    end

    AST_TWO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WR_PC) |=> (state == SQ_WR_NPC));                      // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R6
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == SQ_WR_PC));                                    // R7

endmodule

// File: rtl/trap_entry_seq.sv
// Trap entry sequencer top: state registers, two-cycle write sequence into
// the new window's locals, and fetch redirect to the trap vector.
// Assumes NWIN is a power of two and XLEN >= 16.
module trap_entry_seq #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    localparam int TTW = 8,
    localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int AW  = CW + 4,
    localparam int BW  = XLEN - TTW - 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [TTW-1:0]  trap_type,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_npc,
    input  logic            ld_req,
    input  logic [CW-1:0]   ld_cwp,
    input  logic            ld_sup,
    input  logic            ld_prev_sup,
    input  logic            ld_trap_en,
    input  logic [BW-1:0]   ld_tba,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] new_pc,
    output logic [XLEN-1:0] new_npc,
    output logic [CW-1:0]   cwp,
    output logic            sup,
    output logic            prev_sup,
    output logic            trap_en,
    output logic [XLEN-1:0] tbr,
    output logic            rf_we,
    output logic [AW-1:0]   rf_waddr,
    output logic [XLEN-1:0] rf_wdata
);
    import trap_pkg::*;

    logic                 accept;
    logic                 ld_en;
    seq_state_e           state;
    logic [XLEN-1:0]      ret_pc;
    logic [XLEN-1:0]      ret_npc;
    logic [4:0]           slot;

    trap_seq_fsm #(.XLEN(XLEN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trap_req(trap_req),
        .ld_req  (ld_req),
        .cur_pc  (cur_pc),
        .cur_npc (cur_npc),
        .accept  (accept),
        .ld_en   (ld_en),
        .state   (state),
        .busy    (busy),
        .done    (done),
        .ret_pc  (ret_pc),
        .ret_npc (ret_npc)
    );

    trap_state_regs #(.NWIN(NWIN), .XLEN(XLEN), .TTW(TTW)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .tt         (trap_type),
        .ld_en      (ld_en),
        .ld_cwp     (ld_cwp),
        .ld_sup     (ld_sup),
        .ld_prev_sup(ld_prev_sup),
        .ld_trap_en (ld_trap_en),
        .ld_tba     (ld_tba),
        .busy       (busy),
        .cwp        (cwp),
        .sup        (sup),
        .prev_sup   (prev_sup),
        .trap_en    (trap_en),
        .tbr        (tbr)
    );

    // Select the window-relative slot and data for the current write step.
    always_comb begin
        rf_we    = (state == SQ_WR_PC) || (state == SQ_WR_NPC);
        slot     = (state == SQ_WR_NPC) ? SLOT_RET_NPC : SLOT_RET_PC;
        rf_wdata = (state == SQ_WR_NPC) ? ret_npc : ret_pc;
    end

    trap_win_map #(.NWIN(NWIN)) u_map (
        .win    (cwp),
        .reg_idx(slot),
        .phys   (rf_waddr)
    );

    // Fetch redirect target: trap vector and its successor.
    always_comb begin
        new_pc  = tbr;
        new_npc = tbr + XLEN'(4);
    end

    AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> busy);                                                    // R9
    AST_LOCAL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr[AW-1:4] == cwp &&
                   (rf_waddr[3:0] == 4'd9 || rf_waddr[3:0] == 4'd10)));     // R5
    AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr[3:0] == 4'd9) |=> (rf_we && rf_waddr[3:0] == 4'd10)); // R5

endmodule

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
    localparam int NWIN = 8;
    localparam int XLEN = 32;
    localparam int CW   = 3;
    localparam int AW   = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0;
    logic [7:0]      trap_type = '0;
    logic [XLEN-1:0] cur_pc = '0, cur_npc = '0;
    logic            ld_req = 1'b0;
    logic [CW-1:0]   ld_cwp = '0;
    logic            ld_sup = 1'b0, ld_prev_sup = 1'b0, ld_trap_en = 1'b0;
    logic [19:0]     ld_tba = '0;
    logic            busy, done, sup, prev_sup, trap_en, rf_we;
    logic [XLEN-1:0] new_pc, new_npc, tbr, rf_wdata;
    logic [CW-1:0]   cwp;
    logic [AW-1:0]   rf_waddr;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    trap_entry_seq #(.NWIN(NWIN), .XLEN(XLEN)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] phys(input int w, input int r);
        return (w * 16 + r - 8) % (NWIN * 16);
    endfunction

    // Load state, then trap; optionally hold requests high during busy.
    task automatic run_trap(input int c0, input bit s0, input logic [7:0] tt,
                            input bit hold, input bit same_cycle_ld);
        logic [19:0] base;
        logic [31:0] pcv, npcv, expv;
        int nc;
        base = 20'hA5C3F ^ 20'(c0 << 12) ^ 20'(tt);
        pcv  = 32'h1000_0000 + 32'(c0 * 256) + 32'(tt) * 4;
        npcv = pcv + 32'h10;
        nc   = (c0 + NWIN - 1) % NWIN;
        @(negedge clk);
        ld_req = 1'b1; ld_cwp = CW'(c0); ld_sup = s0; ld_prev_sup = ~s0;
        ld_trap_en = 1'b1; ld_tba = base;
        @(negedge clk);
        ld_req = 1'b0;
        chk("R8 load cwp", 32'(cwp), 32'(c0));
        chk("R8 load bits", {29'b0, sup, prev_sup, trap_en}, {29'b0, s0, ~s0, 1'b1});
        chk("R8 load tbr", tbr, {base, 12'h000});
        trap_req = 1'b1; trap_type = tt; cur_pc = pcv; cur_npc = npcv;
        if (same_cycle_ld) begin
            ld_req = 1'b1; ld_cwp = CW'(c0 + 3);
        end
        @(negedge clk);
        if (hold) begin
            ld_req = 1'b1; ld_cwp = CW'(c0 + 2); ld_tba = ~base;
            trap_type = ~tt; cur_pc = 32'hDEAD_0000;
        end else begin
            trap_req = 1'b0; ld_req = 1'b0;
        end
        expv = {base, tt, 4'h0};
        chk("R2 cwp decrement", 32'(cwp), 32'(nc));
        chk("R3 state bits", {29'b0, sup, prev_sup, trap_en}, {29'b0, 1'b1, s0, 1'b0});
        chk("R4 tbr", tbr, expv);
        chk("R6 busy step1", {31'b0, busy}, 32'd1);
        chk("R6 no done step1", {31'b0, done}, 32'd0);
        chk("R5 we step1", {31'b0, rf_we}, 32'd1);
        chk("R5 addr r17", 32'(rf_waddr), phys(nc, 17));
        chk("R5 data pc", rf_wdata, pcv);
        @(negedge clk);
        trap_req = 1'b0; ld_req = 1'b0;
        chk("R6 busy step2", {31'b0, busy}, 32'd1);
        chk("R6 done", {31'b0, done}, 32'd1);
        chk("R6 new_pc", new_pc, expv);
        chk("R6 new_npc", new_npc, expv + 32'd4);
        chk("R5 we step2", {31'b0, rf_we}, 32'd1);
        chk("R5 addr r18", 32'(rf_waddr), phys(nc, 18));
        chk("R5 data npc", rf_wdata, npcv);
        @(negedge clk);
        chk("R6 idle busy", {31'b0, busy}, 32'd0);
        chk("R6 done pulse end", {31'b0, done}, 32'd0);
        chk("R9 we idle", {31'b0, rf_we}, 32'd0);
        chk("R7 cwp once", 32'(cwp), 32'(nc));
        chk("R7 tbr once", tbr, expv);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog got=%0d exp=<100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 we", {31'b0, rf_we}, 32'd0);
        chk("R1 cwp", 32'(cwp), 32'd0);
        chk("R1 bits", {29'b0, sup, prev_sup, trap_en}, 32'b100);
        chk("R1 tbr", tbr, 32'd0);
        for (int c = 0; c < NWIN; c++) begin
            for (int s = 0; s < 2; s++) begin
                run_trap(c, s[0], 8'(c * 33 + s * 101 + 7), 1'b0, 1'b0);
            end
        end
        run_trap(0, 1'b0, 8'h00, 1'b0, 1'b0);
        run_trap(0, 1'b1, 8'hFF, 1'b0, 1'b0);
        run_trap(NWIN - 1, 1'b1, 8'hFF, 1'b0, 1'b0);
        for (int c = 0; c < NWIN; c++) begin
            run_trap(c, c[0], 8'(8'h5A + c), 1'b1, 1'b0);
        end
        run_trap(0, 1'b0, 8'h3C, 1'b0, 1'b1);
        run_trap(5, 1'b1, 8'hC3, 1'b1, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule